// File: doc/BRIEF.md
# Oversampled SPI Slave Interface

This block is a serial-peripheral slave that lives entirely in the system clock domain. The serial clock, the serial data input and the active-low select are not used as clocks. Each one passes through a two-flop synchronizer, and the block then looks for transitions on the synchronized serial clock. A polarity input sets the idle level of the serial clock. The edge that leaves the idle level (the lead edge) advances the outgoing bit. The edge that returns to idle (the trail edge) captures the incoming bit. The character length is a parameter from 1 to 16 bits, and bits travel most significant first in both directions.

The local side has three parts. A parallel load port fills a transmit holding register. A receive word output holds the last completed character, and a one-cycle strobe marks each completion. While select is low, the first bit of the held word is already on the serial output before any clock edge arrives. Several characters can follow one another under a single select. Raising select in the middle of a character abandons it without a strobe. The output enable is active only while the synchronized select is low.

Top module: `spi_os_slave`

## Requirements
- R1: After reset, rx_done_o is 0, rx_data_o is all zeros and sdo_oe_o is 0.
- R2: With select low, each trail edge shifts sdi_i into the receive register, most significant bit first. After the DATA_W-th trail edge of a character, rx_data_o shows the whole character and rx_done_o pulses. rx_data_o changes at no other time.
- R3: With cpol_i = 0, the clock idles low, the rising edge is the lead edge and the falling edge is the trail edge. Bit i of the character (i = 0 is the MSB) appears on sdo_o within 3 system clocks of lead edge i. The first bit needs no lead edge and is present once select is low. Bit i stays on sdo_o until at least 2 system clocks after the trail edge of bit i.
- R4: With cpol_i = 1, the clock idles high, the falling edge is the lead edge and the rising edge is the trail edge. Timing is otherwise as in R3.
- R5: sdo_oe_o is 1 exactly while select, delayed by the two-flop synchronizer, is low. It is 0 whenever select has been high for 2 or more system clocks.
- R6: Raising select before the last trail edge of a character produces no rx_done_o pulse and clears the bit position. The next frame starts again at the most significant bit.
- R7: Characters sent back to back under one select each produce their own rx_done_o pulse and their own received word.
- R8: tx_load_i = 1 copies tx_data_i into a holding register. The holding register is moved to the shifter while select is high and at the end of each character. A load in the middle of a character does not change the bits of that character.
- R9: Transfers are correct with a serial clock period of 4 system clocks (2 high, 2 low) and at any slower rate.
- R10: Serial clock edges while select is high have no effect on the receive output, the strobe or the bit position.
- R11: rx_done_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Serial clock idle level (0 low, 1 high) |
| sclk_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data from the master |
| sel_ni | input | 1 | Active-low slave select |
| tx_data_i | input | DATA_W | Word for the transmit holding register |
| tx_load_i | input | 1 | Load strobe for tx_data_i |
| rx_data_o | output | DATA_W | Last completed received character |
| rx_done_o | output | 1 | One-cycle strobe on character completion |
| sdo_o | output | 1 | Serial data to the master |
| sdo_oe_o | output | 1 | Output enable for sdo_o (tristate when 0) |

## Verification
The assertions assume that the serial clock stays at each level for at least two system clocks, so synchronized edges are never back to back. They also assume that cpol_i changes only while select is high and that select moves only while the serial clock sits at its idle level. The stimulus holds every half period for 2 to 4 system clocks and changes all inputs on the falling system clock edge. It sets the clock to the new idle level and changes polarity only with select high, and it keeps at least a half period between select and the nearest serial clock edge.

// File: rtl/spi_os_pkg.sv
`timescale 1ns/1ps
package spi_os_pkg;

  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic lead;
    logic trail;
  } sclk_evt_t;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/spi_os_sync.sv
`timescale 1ns/1ps
module spi_os_sync #(
  parameter int unsigned       WIDTH   = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_os_edge.sv
`timescale 1ns/1ps
module spi_os_edge
  import spi_os_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sclk_i,
  input  logic      sel_ni,
  input  logic      cpol_i,
  output sclk_evt_t evt_o
);

  logic sclk_q;
  logic rise, fall, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise   = sclk_i & ~sclk_q;
  assign fall   = ~sclk_i & sclk_q;
  // edges outside a frame are dropped
  assign active = ~sel_ni;

  always_comb begin
    evt_o.lead  = active & (cpol_i ? fall : rise);
    evt_o.trail = active & (cpol_i ? rise : fall);
  end

  // R9
  edge_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o.lead || evt_o.trail) |=> !(evt_o.lead || evt_o.trail));

endmodule

// File: rtl/spi_os_shift.sv
`timescale 1ns/1ps
module spi_os_shift
  import spi_os_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sclk_evt_t         evt_i,
  input  logic              sel_ni,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o,
  output logic              sdo_o
);

  localparam int unsigned         CNT_W = cnt_width(DATA_W);
  localparam logic [CNT_W-1:0]    LAST  = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_buf_q, tx_sr_q, rx_sr_q, rx_data_q;
  logic [DATA_W-1:0] rx_next, tx_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, last_bit;

  assign rx_next  = DATA_W'({rx_sr_q, sdi_i});
  assign tx_next  = DATA_W'({tx_sr_q, 1'b0});
  assign last_bit = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tx_buf_q <= '0;
    else if (tx_load_i) tx_buf_q <= tx_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      cnt_q   <= '0;
    end else if (sel_ni) begin
      tx_sr_q <= tx_buf_q;
      cnt_q   <= '0;
    end else begin
      // bit 0 is already driven at frame start: first lead edge does not shift
      if (evt_i.lead && cnt_q != '0) tx_sr_q <= tx_next;
      if (evt_i.trail) begin
        rx_sr_q <= rx_next;
        if (last_bit) begin
          cnt_q   <= '0;
          tx_sr_q <= tx_buf_q;
        end else begin
          cnt_q   <= CNT_W'(cnt_q + 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= ~sel_ni & evt_i.trail & last_bit;
      if (~sel_ni & evt_i.trail & last_bit) rx_data_q <= rx_next;
    end
  end

  assign rx_data_o = rx_data_q;
  assign rx_done_o = done_q;
  assign sdo_o     = tx_sr_q[DATA_W-1];

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R6
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> (cnt_q == '0));
  // R8
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && !evt_i.lead && !evt_i.trail) |=> $stable(tx_sr_q));
  // R2
  rx_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_q) |-> done_q);

endmodule

// File: rtl/spi_os_slave.sv
`timescale 1ns/1ps
module spi_os_slave
  import spi_os_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              sel_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  logic [2:0] pins_raw, pins_syn;
  logic       sclk_s, sdi_s, sel_s;
  sclk_evt_t  evt;

  assign pins_raw = {sel_ni, sdi_i, sclk_i};

  spi_os_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_syn)
  );

  assign sel_s  = pins_syn[2];
  assign sdi_s  = pins_syn[1];
  assign sclk_s = pins_syn[0];

  spi_os_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sclk_i(sclk_s),
    .sel_ni(sel_s),
    .cpol_i(cpol_i),
    .evt_o (evt)
  );

  spi_os_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .sel_ni   (sel_s),
    .sdi_i    (sdi_s),
    .tx_data_i(tx_data_i),
    .tx_load_i(tx_load_i),
    .rx_data_o(rx_data_o),
    .rx_done_o(rx_done_o),
    .sdo_o    (sdo_o)
  );

  assign sdo_oe_o = ~sel_s;

  // R5: two-flop delay from pin to enable
  oe_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sel_ni, 2) |-> !sdo_oe_o);
  // R5
  oe_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel_ni, 2) |-> sdo_oe_o);

endmodule

// File: tb/spi_os_slave_test.sv
`timescale 1ns/1ps
module spi_os_slave_test;

  localparam int W = 8;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         cpol = 1'b0, sclk = 1'b0, sdi = 1'b0, sel_n = 1'b1, tx_load = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic [W-1:0] rx_data_o;
  logic         rx_done_o, sdo_o, sdo_oe_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0, prev_done = 0;
  logic [W-1:0] cap[$];
  logic [W-1:0] txw[4], rxw[4];

  always #5 clk = ~clk;

  spi_os_slave #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cpol_i(cpol), .sclk_i(sclk), .sdi_i(sdi),
    .sel_ni(sel_n), .tx_data_i(tx_data), .tx_load_i(tx_load),
    .rx_data_o(rx_data_o), .rx_done_o(rx_done_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // R11 monitor
  always @(negedge clk) begin
    if (rx_done_o) begin
      cap.push_back(rx_data_o);
      check(!prev_done, "R11 strobe width", 1, 0);
    end
    prev_done = rx_done_o;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_bit(logic [W-1:0] w, int i);
    return w[W-1-i];
  endfunction

  task automatic load(logic [W-1:0] w);
    tx_data = w; tx_load = 1'b1; tick(1); tx_load = 1'b0;
  endtask

  task automatic run_frame(bit pol, int nchar, int abort_bit, int h);
    int base;
    bit stop;
    string rq;
    stop = 0;
    cpol = pol; sclk = pol; tick(4);
    load(txw[0]); tick(2);
    base = cap.size();
    sel_n = 1'b0; tick(3);
    check(sdo_oe_o == 1'b1, "R5 enable in frame", sdo_oe_o, 1);
    check(sdo_o == exp_bit(txw[0], 0), pol ? "R4 first bit" : "R3 first bit", sdo_o, exp_bit(txw[0], 0));
    tick(h);
    for (int c = 0; c < nchar; c++) begin
      for (int i = 0; i < W; i++) begin
        if (abort_bit >= 0 && i == abort_bit) begin stop = 1; break; end
        sclk = ~pol; sdi = exp_bit(rxw[c], i);
        if (i == 1 && c + 1 < nchar) begin load(txw[c+1]); tick(h - 1); end
        else tick(h);
        sclk = pol; tick(2);
        rq = (c > 0) ? "R8 tx bit" : (pol ? "R4 tx bit" : "R3 tx bit");
        check(sdo_o == exp_bit(txw[c], i), rq, sdo_o, exp_bit(txw[c], i));
        tick(h - 2);
      end
      if (stop) break;
    end
    tick(h); sel_n = 1'b1; tick(4);
    check(sdo_oe_o == 1'b0, "R5 tristate idle", sdo_oe_o, 0);
    if (abort_bit >= 0) begin
      check(cap.size() == base, "R6 no strobe on abort", cap.size() - base, 0);
    end else begin
      check(cap.size() == base + nchar, "R7 strobe count", cap.size() - base, nchar);
      for (int c = 0; c < nchar && base + c < cap.size(); c++)
        check(cap[base+c] == rxw[c], pol ? "R4 rx word" : "R2 rx word", cap[base+c], rxw[c]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int base, h;
    logic [W-1:0] hold;
    void'($urandom(32'd1234));
    tick(3); rst_ni = 1'b1; tick(2);
    // R1
    check(rx_done_o == 1'b0, "R1 strobe", rx_done_o, 0);
    check(rx_data_o == '0, "R1 rx data", rx_data_o, 0);
    check(sdo_oe_o == 1'b0, "R1 enable", sdo_oe_o, 0);

    // R9: fastest clock, both polarities
    txw[0] = 8'hA5; rxw[0] = 8'h3C;
    base = cap.size();
    run_frame(1'b0, 1, -1, 2);
    check(cap.size() == base + 1, "R9 ratio four", cap.size() - base, 1);
    txw[0] = 8'h81; rxw[0] = 8'hE7;
    run_frame(1'b1, 1, -1, 2);

    // R6: abort then clean frame
    txw[0] = 8'hFF; rxw[0] = 8'h00;
    run_frame(1'b0, 1, 5, 3);
    txw[0] = 8'h5A; rxw[0] = 8'hC3;
    run_frame(1'b0, 1, -1, 3);
    check(cap[cap.size()-1] == 8'hC3, "R6 realigned", cap[cap.size()-1], 8'hC3);

    // R10: toggling with select high
    hold = rx_data_o; base = cap.size();
    cpol = 1'b0; sclk = 1'b0; sdi = 1'b1;
    for (int k = 0; k < 12; k++) begin sclk = ~sclk; tick(2); end
    tick(4);
    check(cap.size() == base, "R10 no strobe", cap.size() - base, 0);
    check(rx_data_o == hold, "R10 rx held", rx_data_o, hold);
    check(sdo_oe_o == 1'b0, "R10 tristate", sdo_oe_o, 0);
    txw[0] = 8'h12; rxw[0] = 8'h34;
    run_frame(1'b0, 1, -1, 2);

    // R7, R8: back-to-back characters
    txw[0] = 8'hF0; txw[1] = 8'h0F; txw[2] = 8'h99;
    rxw[0] = 8'h01; rxw[1] = 8'h80; rxw[2] = 8'h7E;
    run_frame(1'b1, 3, -1, 2);

    // random mix
    for (int n = 0; n < 40; n++) begin
      bit pol;
      int nc, ab;
      pol = 1'($urandom % 2);
      nc  = 1 + int'($urandom % 3);
      h   = 2 + int'($urandom % 3);
      ab  = -1;
      if ($urandom % 5 == 0) begin nc = 1; ab = int'($urandom % W); end
      for (int c = 0; c < 4; c++) begin
        txw[c] = W'($urandom);
        rxw[c] = W'($urandom);
      end
      run_frame(pol, nc, ab, h);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule